// File: doc/BRIEF.md
# Descriptor-chain DMA engine

This block is a single-channel memory-to-memory DMA engine that moves a sequence of buffers described by a chain of descriptors in system memory. Software stores the address of the first descriptor in a pointer register and then writes 1 to the enable bit. The engine reads the five descriptor words and copies the buffer one 32-bit word at a time over a single-beat master port. It then writes an updated control A word back into the descriptor. While the chain continues, it follows the next pointer to the following descriptor.

A descriptor is five consecutive words: source address (+0x0), destination address (+0x4), next pointer (+0x8), control A (+0xC) and control B (+0x10). Control A carries the buffer length in words in bits [15:0] and a done flag in bit 31. Control B bit 0 is a stop flag. Software tracks progress by polling the done flag in each in-memory descriptor. Two sticky status bits, which clear on read, report buffer completion and chain completion, and they also drive the two interrupt outputs.

Top module: `dchain_dma`

## Requirements
- R1: Writing a word with bit 0 set to the control register (reg_addr 0x0) while the channel is idle sets the enable bit and starts the chain at the address held in the pointer register (reg_addr 0x4). A write with bit 0 clear, or any control write while the channel runs, starts nothing and performs no memory access.
- R2: For each descriptor the engine first reads the five words at descriptor addresses +0x0, +0x4, +0x8, +0xC and +0x10, in that order. The source, destination, next pointer and both control words all come from those reads.
- R3: The buffer is copied as control A [15:0] read-then-write word pairs. The source and destination addresses each step by 4, and no destination word beyond the buffer is written.
- R4: After a buffer, exactly one write goes to descriptor +0xC. It carries bit 31 set, bits [15:0] equal to the number of words moved, and bits [30:16] as fetched.
- R5: After the write-back the engine goes on to the descriptor at the next pointer without waiting for the buffer-complete status to be read.
- R6: The chain ends after the buffer whose descriptor has control B bit 0 set, or whose next pointer is zero. At that point the enable bit (control register bit 0) reads back 0.
- R7: The status register (reg_addr 0x8) holds bit 0 (a buffer completed) and bit 1 (the chain completed). Both bits are sticky, a read returns them and clears them, and irq_buf and irq_xfer show bit 0 and bit 1.
- R8: A buffer with control A [15:0] equal to zero moves no data but still performs the write-back with the done flag set and a count of zero.
- R9: A master request keeps mem_req high with a stable address and direction until mem_ready is sampled high. Read data is taken and write data is accepted in that same cycle.
- R10: After reset all registers read 0, both interrupts are low and the master port is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| mem_req | output | 1 | Master request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Master byte address |
| mem_wdata | output | 32 | Master write data |
| mem_ready | input | 1 | Slave completes the current request |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| irq_buf | output | 1 | Buffer-complete status |
| irq_xfer | output | 1 | Chain-complete status |

## Verification
The properties assume that the memory slave asserts mem_ready only while a request is pending. They also assume that software starts the channel only after it has built a well-formed chain whose descriptors and buffers do not overlap. The bench's memory model answers only pending requests, with a stall of zero to two cycles. Every chain it builds keeps descriptors, sources and destinations in separate regions, so a write-back or a copy never corrupts a word that a later fetch depends on.

// File: rtl/dchain_pkg.sv
// Shared constants and types for the descriptor-chain DMA engine.
// Assumes 32-bit data words and byte addressing with word-aligned accesses.
package dchain_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 5;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int REG_AW     = 4;

    // descriptor word positions (the engine fetches them in this order)
    localparam int D_SRC  = 0;
    localparam int D_DST  = 1;
    localparam int D_NEXT = 2;
    localparam int D_CTLA = 3;
    localparam int D_CTLB = 4;

    // register offsets, selected by reg_addr[3:2]
    localparam logic [1:0] RS_CTRL   = 2'd0;
    localparam logic [1:0] RS_PTR    = 2'd1;
    localparam logic [1:0] RS_STATUS = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READ,
        ST_WRITE,
        ST_WBACK
    } eng_state_e;
endpackage

// File: rtl/dchain_regs.sv
// Register slave of the DMA engine: control, first-descriptor pointer and status.
// Assumes single-cycle strobes; read data is registered and holds until the next read.
module dchain_regs
    import dchain_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              buf_done,
    input  logic              chain_done,
    output logic              start,
    output logic [AW-1:0]     first_ptr,
    output logic              irq_buf,
    output logic              irq_xfer
);
    logic       en_q;
    logic [1:0] stat_q;
    logic       wr_any;
    logic       rd_any;
    logic [1:0] sel;

    assign sel    = reg_addr[3:2];
    assign wr_any = reg_sel && reg_wr;
    assign rd_any = reg_sel && !reg_wr;
    assign start  = wr_any && (sel == RS_CTRL) && reg_wdata[0] && !en_q;

    // enable bit: set by a start write, cleared when the chain ends
    always_ff @(posedge clk) begin
        if (!rst_n)          en_q <= 1'b0;
        else if (start)      en_q <= 1'b1;
        else if (chain_done) en_q <= 1'b0;
    end

    // first descriptor pointer, writable only while idle
    always_ff @(posedge clk) begin
        if (!rst_n)                                   first_ptr <= '0;
        else if (wr_any && sel == RS_PTR && !en_q)    first_ptr <= reg_wdata[AW-1:0];
    end

    // sticky status bits: new events win over a clear-on-read in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else begin
            stat_q <= ((rd_any && sel == RS_STATUS) ? 2'b00 : stat_q)
                      | {chain_done, buf_done};
        end
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) reg_rdata <= '0;
        else if (rd_any) begin
            case (sel)
                RS_CTRL:   reg_rdata <= {{(WORD_W-1){1'b0}}, en_q};
                RS_PTR:    reg_rdata <= WORD_W'(first_ptr);
                RS_STATUS: reg_rdata <= {{(WORD_W-2){1'b0}}, stat_q};
                default:   reg_rdata <= '0;
            endcase
        end
    end

    assign irq_buf  = stat_q[0];
    assign irq_xfer = stat_q[1];
endmodule

// File: rtl/dchain_engine.sv
// Channel engine: fetches descriptors, copies buffers word by word, writes back
// control A and follows the chain. Assumes mem_ready only while mem_req is high.
module dchain_engine
    import dchain_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     first_ptr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              buf_done,
    output logic              chain_done,
    output logic              busy,
    output logic              wb_phase
);
    localparam logic [AW-1:0] STEP    = AW'(4);
    localparam logic [AW-1:0] CTLA_OF = AW'(4 * D_CTLA);

    eng_state_e        state;
    logic [IDX_W-1:0]  widx;
    logic [AW-1:0]     desc_addr;
    logic [AW-1:0]     src_cur;
    logic [AW-1:0]     dst_cur;
    logic [AW-1:0]     nxt_ptr;
    logic [WORD_W-1:0] ctla;
    logic [WORD_W-1:0] ctlb;
    logic [WORD_W-1:0] data_q;
    logic [CW-1:0]     moved;
    logic [CW-1:0]     moved_inc;
    logic              ack;
    logic              last_desc;
    logic [WORD_W-1:0] wb_word;

    assign ack       = mem_req && mem_ready;
    assign moved_inc = moved + 1'b1;
    assign last_desc = ctlb[0] || (nxt_ptr == '0);
    assign wb_word   = {1'b1, ctla[WORD_W-2:CW], moved};

    // main sequencer and working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            widx      <= '0;
            desc_addr <= '0;
            src_cur   <= '0;
            dst_cur   <= '0;
            nxt_ptr   <= '0;
            ctla      <= '0;
            ctlb      <= '0;
            data_q    <= '0;
            moved     <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    desc_addr <= first_ptr;
                    widx      <= '0;
                    state     <= ST_FETCH;
                end
                ST_FETCH: if (ack) begin
                    case (int'(widx))
                        D_SRC:   src_cur <= mem_rdata[AW-1:0];
                        D_DST:   dst_cur <= mem_rdata[AW-1:0];
                        D_NEXT:  nxt_ptr <= mem_rdata[AW-1:0];
                        D_CTLA:  ctla    <= mem_rdata;
                        default: ctlb    <= mem_rdata;
                    endcase
                    if (int'(widx) == DESC_WORDS - 1) begin
                        moved <= '0;
                        state <= (ctla[CW-1:0] == '0) ? ST_WBACK : ST_READ;
                    end else begin
                        widx <= widx + 1'b1;
                    end
                end
                ST_READ: if (ack) begin
                    data_q <= mem_rdata;
                    state  <= ST_WRITE;
                end
                ST_WRITE: if (ack) begin
                    src_cur <= src_cur + STEP;
                    dst_cur <= dst_cur + STEP;
                    moved   <= moved_inc;
                    state   <= (moved_inc == ctla[CW-1:0]) ? ST_WBACK : ST_READ;
                end
                ST_WBACK: if (ack) begin
                    if (last_desc) begin
                        state <= ST_IDLE;
                    end else begin
                        desc_addr <= nxt_ptr;
                        widx      <= '0;
                        state     <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // master port drive, decoded from the current state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + (AW'(widx) << 2);
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_cur;
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_cur;
                mem_wdata = data_q;
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + CTLA_OF;
                mem_wdata = wb_word;
            end
            default: ;
        endcase
    end

    assign buf_done   = (state == ST_WBACK) && ack;
    assign chain_done = buf_done && last_desc;
    assign busy       = (state != ST_IDLE);
    assign wb_phase   = (state == ST_WBACK);
endmodule

// File: rtl/dchain_dma.sv
// Top of the descriptor-chain DMA engine: register slave plus channel engine.
// Assumes a single-beat memory slave that answers only pending requests.
module dchain_dma
    import dchain_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              irq_buf,
    output logic              irq_xfer
);
    logic          start;
    logic [AW-1:0] first_ptr;
    logic          buf_done;
    logic          chain_done;
    logic          eng_busy;
    logic          eng_wb;

    dchain_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_sel    (reg_sel),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .buf_done   (buf_done),
        .chain_done (chain_done),
        .start      (start),
        .first_ptr  (first_ptr),
        .irq_buf    (irq_buf),
        .irq_xfer   (irq_xfer)
    );

    dchain_engine #(.AW(AW), .CW(CW)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .first_ptr  (first_ptr),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .buf_done   (buf_done),
        .chain_done (chain_done),
        .busy       (eng_busy),
        .wb_phase   (eng_wb)
    );
endmodule

// File: rtl/dchain_chk.sv
// Protocol and sequencing properties for dchain_dma, attached by bind.
// Assumes mem_ready is asserted only while a request is pending.
module dchain_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          busy,
    input logic          wb_phase,
    input logic          irq_xfer
);
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    p_start_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mem_req && !mem_we);

    p_wb_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_phase |-> mem_req && mem_we && mem_wdata[31]);

    p_end_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_xfer) |-> $fell(busy));
endmodule

bind dchain_dma dchain_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (eng_busy),
    .wb_phase  (eng_wb),
    .irq_xfer  (irq_xfer)
);

// File: tb/dchain_dma_test.sv
module dchain_dma_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        irq_buf, irq_xfer;

    int total = 0, bad = 0;
    int n_rd = 0, n_wr = 0, proto_bad = 0;
    int stall = 0, stall_seed = 0;
    logic [31:0] mem [256];
    logic        p_req, p_rdy, p_we;
    logic [31:0] p_addr;

    dchain_dma uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .irq_buf(irq_buf), .irq_xfer(irq_xfer)
    );

    always #5 clk = ~clk;

    // memory slave with 0..2 stall cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            mem_rdata <= '0;
            stall     <= 0;
        end else if (mem_ready) begin
            mem_ready <= 1'b0;
            if (mem_we) begin mem[mem_addr[9:2]] <= mem_wdata; n_wr <= n_wr + 1; end
            else n_rd <= n_rd + 1;
        end else if (mem_req) begin
            if (stall == 0) begin
                mem_ready  <= 1'b1;
                mem_rdata  <= mem[mem_addr[9:2]];
                stall_seed <= stall_seed + 1;
                stall      <= (stall_seed * 7) % 3;
            end else stall <= stall - 1;
        end
    end

    // R9 observed at the ports: held request keeps address and direction
    always @(negedge clk) begin
        if (rst_n && p_req && !p_rdy && (!mem_req || mem_addr != p_addr || mem_we != p_we))
            proto_bad++;
        p_req = mem_req; p_rdy = mem_ready; p_addr = mem_addr; p_we = mem_we;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_sel = 0; reg_wr = 0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_sel = 1; reg_wr = 0; reg_addr = a;
        @(negedge clk); reg_sel = 0; d = reg_rdata;
    endtask

    task automatic wait_end(input string req);
        int n = 0;
        while (!irq_xfer && n < 3000) begin @(negedge clk); n++; end
        check(req, {31'd0, irq_xfer}, 32'd1);
    endtask

    task automatic put_desc(input int w, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] nx, input logic [31:0] ca, input logic [31:0] cb);
        mem[w] = s; mem[w+1] = d; mem[w+2] = nx; mem[w+3] = ca; mem[w+4] = cb;
    endtask

    task automatic fill();
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + i;
        for (int i = 64; i < 128; i++) mem[i] = 32'hA500_0000 + i * 32'h1111;
    endtask

    initial begin
        logic [31:0] r;
        fill();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10 reset state
        check("R10 irq", {30'd0, irq_xfer, irq_buf}, 32'd0);
        check("R10 mem_req", {31'd0, mem_req}, 32'd0);
        reg_read(4'h0, r); check("R10 ctrl", r, 32'd0);
        reg_read(4'h4, r); check("R10 ptr", r, 32'd0);
        reg_read(4'h8, r); check("R10 status", r, 32'd0);

        // R1: a control write with bit 0 clear starts nothing
        reg_write(4'h4, 32'h40);
        reg_write(4'h0, 32'h0);
        repeat (20) @(negedge clk);
        check("R1 no start", n_rd + n_wr, 0);

        // sweep single-descriptor buffers of 0..4 words, two ways of ending
        for (int sz = 0; sz <= 4; sz++) begin
            for (int stop = 0; stop < 2; stop++) begin
                logic [31:0] ca;
                fill();
                ca = 32'h0055_0000 | sz;
                put_desc(16, 32'h100, 32'h200, stop ? 32'h60 : 32'h0, ca, stop ? 32'h1 : 32'h0);
                n_rd = 0; n_wr = 0;
                reg_write(4'h4, 32'h40);
                reg_write(4'h0, 32'h1);
                wait_end("R6 single end");
                repeat (2) @(negedge clk);
                check("R2 reads", n_rd, 5 + sz);
                check("R3 writes", n_wr, sz + 1);
                for (int i = 0; i < sz; i++)
                    check("R3 copy", mem[128 + i], 32'hA500_0000 + (64 + i) * 32'h1111);
                check(sz == 0 ? "R8 no data" : "R3 guard", mem[128 + sz], 32'hDEAD_0000 + 128 + sz);
                check(sz == 0 ? "R8 wb" : "R4 wb", mem[19], 32'h8055_0000 | sz);
                check("R4 others", mem[18], stop ? 32'h60 : 32'h0);
                reg_read(4'h0, r); check("R6 enable clear", r, 32'd0);
                reg_read(4'h8, r); check("R7 status", r, 32'd3);
                check("R7 irq after read", {30'd0, irq_xfer, irq_buf}, 32'd0);
                reg_read(4'h8, r); check("R7 cleared", r, 32'd0);
            end
        end

        // R5/R6: chain of three, status never read; stop bit ends despite nonzero next
        fill();
        put_desc(16, 32'h100, 32'h200, 32'h58, 32'h0000_0002, 32'h0);
        put_desc(22, 32'h110, 32'h220, 32'h70, 32'h0012_0003, 32'h0);
        put_desc(28, 32'h120, 32'h240, 32'h90, 32'h0000_0001, 32'h1);
        put_desc(36, 32'h100, 32'h3F0, 32'h0, 32'h0000_0004, 32'h0);
        n_rd = 0; n_wr = 0;
        reg_write(4'h4, 32'h40);
        reg_write(4'h0, 32'h1);
        // R1: writes while running are ignored
        reg_write(4'h4, 32'h90);
        reg_write(4'h0, 32'h1);
        wait_end("R5 chain end");
        repeat (2) @(negedge clk);
        check("R5 reads", n_rd, 15 + 6);
        check("R5 writes", n_wr, 6 + 3);
        check("R4 wb0", mem[19], 32'h8000_0002);
        check("R4 wb1", mem[25], 32'h8012_0003);
        check("R4 wb2", mem[31], 32'h8000_0001);
        check("R6 stop wins", mem[39], 32'h0000_0004);
        check("R5 copy b1", mem[136 + 2], 32'hA500_0000 + (68 + 2) * 32'h1111);
        check("R5 copy b2", mem[144], 32'hA500_0000 + 72 * 32'h1111);
        check("R1 unused dst", mem[252], 32'hDEAD_0000 + 252);
        reg_read(4'h4, r); check("R1 ptr kept", r, 32'h40);
        reg_read(4'h8, r); check("R7 status chain", r, 32'd3);
        check("R9 protocol", proto_bad, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule